// File: doc/BRIEF.md
# Delayed-Read Bus Target

This block is the target side of a PCI-style bus interface that sits in front of slow memory and register space. A read of that space cannot be answered inside one bus cycle. On the first attempt the block records the request and answers with Retry. A sequencer then fetches the data through a 16-bit back-end port, one or two halfword accesses per request. The master keeps repeating the identical read. Each repeat is retried until the data is held at the interface. The repeat that finds the data completes with a single data phase and a disconnect.

Only one delayed read is held at a time. A new one is accepted only while the local posted-write FIFO reports empty. A small status window is answered at once and never enters the delayed path, so software can poll the FIFO state without using retries. Memory space accepts every byte-enable pattern. Register space aborts partial-halfword requests and returns zeros for requests that do not touch the lower halfword.

Top module: `dread_target`

## Requirements
- R1: A delayable read that arrives with nothing pending and `wfifo_empty` high is answered Retry (`rsp_kind` 2'b01) and starts back-end fetches for that request.
- R2: A delayable read that arrives with `wfifo_empty` low, and nothing pending, is answered Retry and starts no back-end access.
- R3: Repeats of the pending request are answered Retry until all its halfwords are fetched. The first repeat after that is answered Data-with-disconnect (`rsp_kind` 2'b00) carrying the fetched word, and the entry is then free.
- R4: A repeat matches only if space, address, command and byte enables are all identical. Any other delayable read while an entry is pending gets Retry and leaves the entry and its fetches unchanged.
- R5: Register-space reads at 0x800 to 0x81C are answered Data in the next cycle, with no back-end access, whatever the FIFO state. At 0x800, bit 31 = entry pending, bit 30 = write FIFO not empty, bit 29 = data ready, and all other bits are 0. The other offsets read 0.
- R6: Memory-space reads accept any byte enables. A halfword is fetched when any of its enables is set, or the lower halfword alone is fetched when none is set. The lower halfword is fetched before the upper one. Each fetch puts `{addr[11:2], half}` on `bk_haddr`. A fetched halfword is returned whole, and an unfetched halfword reads 0.
- R7: A register-space read at 0x000 to 0x0FC that enables exactly one byte of either halfword is answered Target Abort (`rsp_kind` 2'b10) with data 0, and nothing is queued.
- R8: A register-space read at 0x000 to 0x0FC whose lower-halfword enables are both clear, and that is not aborted by R7, is answered Data with value 0 at once, and nothing is queued.
- R9: A register-space read at 0x000 to 0x0FC with both lower enables set is delayed. It uses one lower-halfword fetch, and the returned upper halfword is 0.
- R10: Register-space reads outside 0x000 to 0x0FC and 0x800 to 0x81C are answered Target Abort.
- R11: During and right after reset, `rsp_valid` and `bk_rd` are low and the status word shows nothing pending.
- R12: Every cycle with `req_valid` high gives exactly one `rsp_valid` pulse in the following cycle. No response appears otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfifo_empty | input | 1 | Posted-write FIFO is empty |
| req_valid | input | 1 | A read attempt is presented this cycle |
| req_reg | input | 1 | 1 = register space, 0 = memory space |
| req_addr | input | ADDR_W | Byte address of the read |
| req_cmd | input | CMD_W | Bus command code |
| req_be | input | DATA_W/8 | Byte enables, 1 = byte requested |
| rsp_valid | output | 1 | Termination for last cycle's attempt |
| rsp_kind | output | 2 | 00 data+disconnect, 01 retry, 10 target abort |
| rsp_data | output | DATA_W | Returned word |
| bk_rd | output | 1 | One-cycle back-end halfword read strobe |
| bk_reg | output | 1 | Space of the back-end read |
| bk_haddr | output | ADDR_W-1 | Halfword address of the back-end read |
| bk_rvalid | input | 1 | One-cycle back-end read completion |
| bk_rdata | input | DATA_W/2 | Back-end read data |

## Verification
The bench uses the default build: 12-bit addresses, a 32-bit bus word and a 4-bit command. With these values the status window, the register window and the unmapped register range all lie inside the address space. Each memory word splits into two halves, so both the one-fetch and the two-fetch sequences occur. Random addresses are drawn from small pools, and the back-end latency is random. As a result, exact repeats, near-miss repeats, status polls during a fetch and FIFO-busy attempts all arrive while an entry sits in every sequencer state.

// File: rtl/dread_target.sv
module dread_target #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CMD_W = 4,
  parameter logic [ADDR_W-1:0] REG_LAST = 'h0FC,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h800,
  parameter logic [ADDR_W-1:0] STAT_LAST = 'h81C
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wfifo_empty,
  input  logic                             req_valid,
  input  logic                             req_reg,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic [CMD_W-1:0]                 req_cmd,
  input  logic [DATA_W/8-1:0]              req_be,
  output logic                             rsp_valid,
  output logic [1:0]                       rsp_kind,
  output logic [DATA_W-1:0]                rsp_data,
  output logic                             bk_rd,
  output logic                             bk_reg,
  output logic [ADDR_W-$clog2(DATA_W/8):0] bk_haddr,
  input  logic                             bk_rvalid,
  input  logic [DATA_W/2-1:0]              bk_rdata
);

  localparam int BE_W   = DATA_W / 8;
  localparam int HBE    = BE_W / 2;
  localparam int HALF_W = DATA_W / 2;
  localparam int WB     = $clog2(BE_W);
  localparam logic [1:0] K_DATA  = 2'b00;
  localparam logic [1:0] K_RETRY = 2'b01;
  localparam logic [1:0] K_ABORT = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_READY} st_t;

  st_t               st;
  logic              q_reg;
  logic [ADDR_W-1:0] q_addr;
  logic [CMD_W-1:0]  q_cmd;
  logic [BE_W-1:0]   q_be;
  logic              need_hi, cur_hi;
  logic [HALF_W-1:0] buf_lo, buf_hi;

  logic [HBE-1:0] lo_be, hi_be;
  assign lo_be = req_be[HBE-1:0];
  assign hi_be = req_be[BE_W-1:HBE];

  logic lo_part, hi_part;
  assign lo_part = (lo_be != '0) && (lo_be != '1);
  assign hi_part = (hi_be != '0) && (hi_be != '1);

  logic in_stat, in_regs, reg_abort, reg_zero, bad_reg, delay_ok;
  assign in_stat   = req_reg && (req_addr >= STAT_BASE) && (req_addr <= STAT_LAST);
  assign in_regs   = req_reg && (req_addr <= REG_LAST);
  assign reg_abort = in_regs && (lo_part || hi_part);
  assign reg_zero  = in_regs && !reg_abort && (lo_be == '0);
  assign bad_reg   = req_reg && !in_regs && !in_stat;
  assign delay_ok  = !req_reg || (in_regs && !reg_abort && !reg_zero);

  logic pend, ready, match, deliver, enq, need_lo_n, need_hi_n;
  assign pend    = (st != S_IDLE);
  assign ready   = (st == S_READY);
  assign match   = pend && (q_reg == req_reg) && (q_addr == req_addr) &&
                   (q_cmd == req_cmd) && (q_be == req_be);
  assign deliver = req_valid && delay_ok && match && ready;
  assign enq     = req_valid && delay_ok && !pend && wfifo_empty;

  assign need_lo_n = req_reg || (lo_be != '0) || (hi_be == '0);
  assign need_hi_n = !req_reg && (hi_be != '0);

  logic [1:0]        nxt_kind;
  logic [DATA_W-1:0] nxt_data, stat_word;

  always_comb begin
    stat_word = '0;
    if (req_addr == STAT_BASE) begin
      stat_word[DATA_W-1] = pend;
      stat_word[DATA_W-2] = !wfifo_empty;
      stat_word[DATA_W-3] = ready;
    end
    nxt_kind = K_RETRY;
    nxt_data = '0;
    if (in_stat) begin
      nxt_kind = K_DATA;
      nxt_data = stat_word;
    end else if (bad_reg || reg_abort) begin
      nxt_kind = K_ABORT;
    end else if (reg_zero) begin
      nxt_kind = K_DATA;
    end else if (deliver) begin
      nxt_kind = K_DATA;
      nxt_data = {buf_hi, buf_lo};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= K_DATA;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_kind  <= req_valid ? nxt_kind : K_DATA;
      rsp_data  <= req_valid ? nxt_data : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      q_reg   <= 1'b0;
      q_addr  <= '0;
      q_cmd   <= '0;
      q_be    <= '0;
      need_hi <= 1'b0;
      cur_hi  <= 1'b0;
      buf_lo  <= '0;
      buf_hi  <= '0;
    end else begin
      case (st)
        S_IDLE: if (enq) begin
          st      <= S_ISSUE;
          q_reg   <= req_reg;
          q_addr  <= req_addr;
          q_cmd   <= req_cmd;
          q_be    <= req_be;
          need_hi <= need_hi_n;
          cur_hi  <= !need_lo_n;
          buf_lo  <= '0;
          buf_hi  <= '0;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (bk_rvalid) begin
          if (cur_hi) buf_hi <= bk_rdata;
          else        buf_lo <= bk_rdata;
          if (!cur_hi && need_hi) begin
            cur_hi <= 1'b1;
            st     <= S_ISSUE;
          end else begin
            st <= S_READY;
          end
        end
        S_READY: if (deliver) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bk_rd    = (st == S_ISSUE);
  assign bk_reg   = q_reg;
  assign bk_haddr = {q_addr[ADDR_W-1:WB], cur_hi};

endmodule

// File: rtl/dread_target_chk.sv
module dread_target_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_LAST = 'h0FC,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h800,
  parameter logic [ADDR_W-1:0] STAT_LAST = 'h81C
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wfifo_empty,
  input logic                req_valid,
  input logic                req_reg,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [DATA_W/8-1:0] req_be,
  input logic                rsp_valid,
  input logic [1:0]          rsp_kind,
  input logic [DATA_W-1:0]   rsp_data,
  input logic                bk_rd,
  input logic                pend,
  input logic                ready
);
  localparam int BE_W = DATA_W / 8;
  localparam int HBE  = BE_W / 2;

  logic stat_hit, regs_hit, part_hit;
  assign stat_hit = req_reg && req_addr >= STAT_BASE && req_addr <= STAT_LAST;
  assign regs_hit = req_reg && req_addr <= REG_LAST;
  assign part_hit = ($countones(req_be[HBE-1:0]) == 1) || ($countones(req_be[BE_W-1:HBE]) == 1);

  p_rsp_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_kind_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_kind != 2'b11);
  p_status_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && stat_hit) |=> rsp_kind == 2'b00);
  p_regbyte_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && regs_hit && part_hit) |=> rsp_kind == 2'b10 && rsp_data == '0);
  p_fifo_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_reg && !pend && !wfifo_empty) |=> rsp_kind == 2'b01 && !pend);
  p_fetch_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bk_rd |=> !bk_rd);
  p_fetch_owned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bk_rd |-> pend && !ready);
  p_entry_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ready) |=> pend);
endmodule

bind dread_target dread_target_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_LAST(REG_LAST),
  .STAT_BASE(STAT_BASE), .STAT_LAST(STAT_LAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wfifo_empty(wfifo_empty), .req_valid(req_valid),
  .req_reg(req_reg), .req_addr(req_addr), .req_be(req_be), .rsp_valid(rsp_valid),
  .rsp_kind(rsp_kind), .rsp_data(rsp_data), .bk_rd(bk_rd), .pend(pend), .ready(ready)
);

// File: tb/dread_target_bench.sv
module dread_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int CMD_W  = 4;
  localparam int HA_W   = ADDR_W - 1;

  logic clk = 1'b0, rst_n = 1'b0, wfifo_empty = 1'b1;
  logic req_valid = 1'b0, req_reg = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CMD_W-1:0] req_cmd = '0;
  logic [3:0] req_be = '0;
  logic rsp_valid, bk_rd, bk_reg;
  logic [1:0] rsp_kind;
  logic [DATA_W-1:0] rsp_data;
  logic [HA_W-1:0] bk_haddr;
  logic bk_rvalid = 1'b0;
  logic [15:0] bk_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dread_target u_dread_target (
    .clk(clk), .rst_n(rst_n), .wfifo_empty(wfifo_empty), .req_valid(req_valid),
    .req_reg(req_reg), .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .bk_rd(bk_rd), .bk_reg(bk_reg), .bk_haddr(bk_haddr),
    .bk_rvalid(bk_rvalid), .bk_rdata(bk_rdata));

  int n_checks = 0, n_fail = 0;

  bit m_pend = 0, m_ready = 0, m_reg = 0, m_need_lo = 0, m_need_hi = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [CMD_W-1:0] m_cmd = '0;
  logic [3:0] m_be = '0;
  int m_need = 0, m_issued = 0, m_done = 0;
  bit bk_busy = 0, rv_drv = 0;
  int bk_cnt = 0;
  logic [HA_W-1:0] bk_cur = '0;
  bit bk_cur_reg = 0;
  bit e_valid = 0;
  logic [1:0] e_kind = '0;
  logic [31:0] e_data = '0;
  string e_tag = "R12";

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] bkval(input logic r, input logic [HA_W-1:0] ha);
    return 16'h3C5A ^ {r, 4'b1001, ha};
  endfunction

  function automatic bit partial(input logic [1:0] h);
    return h == 2'b01 || h == 2'b10;
  endfunction

  task automatic step(input bit v, input bit r, input logic [ADDR_W-1:0] a,
                      input logic [CMD_W-1:0] c, input logic [3:0] be, input bit fe);
    bit in_stat, in_regs, match;
    logic [15:0] lo_w, hi_w;
    @(negedge clk);
    if (e_valid) begin
      check(e_tag, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
      check(e_tag, "rsp_kind", {30'b0, rsp_kind}, {30'b0, e_kind});
      check(e_tag, "rsp_data", rsp_data, e_data);
    end else begin
      check("R12", "idle rsp_valid", {31'b0, rsp_valid}, 32'd0);
    end
    if (rv_drv) begin
      rv_drv = 0; bk_rvalid = 1'b0; bk_busy = 0; m_done++;
      if (m_done == m_need) m_ready = 1;
    end else if (bk_busy) begin
      if (bk_cnt == 0) begin
        bk_rvalid = 1'b1; bk_rdata = bkval(bk_cur_reg, bk_cur); rv_drv = 1;
      end else bk_cnt--;
    end
    if (bk_rd) begin
      check("R1", "fetch expected", 32'd1, {31'b0, m_pend && !bk_busy && m_issued < m_need});
      check("R6", "fetch haddr", {21'b0, bk_haddr},
            {21'b0, m_addr[ADDR_W-1:2], !(m_need_lo && m_issued == 0)});
      check("R6", "fetch space", {31'b0, bk_reg}, {31'b0, m_reg});
      m_issued++; bk_busy = 1; bk_cnt = 1 + int'($urandom % 4);
      bk_cur = bk_haddr; bk_cur_reg = bk_reg;
    end
    wfifo_empty = fe; req_valid = v; req_reg = r; req_addr = a; req_cmd = c; req_be = be;
    e_valid = v; e_kind = 2'b01; e_data = '0; e_tag = "R12";
    if (!v) return;
    in_stat = r && a >= 12'h800 && a <= 12'h81C;
    in_regs = r && a <= 12'h0FC;
    if (in_stat) begin
      e_kind = 2'b00; e_tag = "R5";
      if (a == 12'h800) e_data = {m_pend, !fe, m_ready, 29'b0};
    end else if (r && !in_regs) begin
      e_kind = 2'b10; e_tag = "R10";
    end else if (in_regs && (partial(be[1:0]) || partial(be[3:2]))) begin
      e_kind = 2'b10; e_tag = "R7";
    end else if (in_regs && be[1:0] == 2'b00) begin
      e_kind = 2'b00; e_tag = "R8";
    end else begin
      match = m_pend && r == m_reg && a == m_addr && c == m_cmd && be == m_be;
      if (match && m_ready) begin
        lo_w = m_need_lo ? bkval(m_reg, {m_addr[ADDR_W-1:2], 1'b0}) : 16'h0;
        hi_w = m_need_hi ? bkval(m_reg, {m_addr[ADDR_W-1:2], 1'b1}) : 16'h0;
        e_kind = 2'b00; e_data = {hi_w, lo_w}; e_tag = r ? "R9" : "R3";
        m_pend = 0; m_ready = 0;
      end else if (m_pend) begin
        e_tag = match ? "R3" : "R4";
      end else if (fe) begin
        e_tag = "R1";
        m_pend = 1; m_ready = 0; m_reg = r; m_addr = a; m_cmd = c; m_be = be;
        m_need_lo = r || be[1:0] != 0 || be == 0;
        m_need_hi = !r && be[3:2] != 0;
        m_need = int'(m_need_lo) + int'(m_need_hi);
        m_issued = 0; m_done = 0;
      end else begin
        e_tag = "R2";
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, '0, 1);
  endtask

  task automatic finish_pending();
    for (int i = 0; i < 40 && m_pend; i++) step(1, m_reg, m_addr, m_cmd, m_be, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R11", "reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R11", "reset bk_rd", {31'b0, bk_rd}, 32'd0);
    rst_n = 1'b1;
    step(1, 1, 12'h800, 4'h6, 4'hF, 1);            // R11 status after reset, R5
    step(1, 0, 12'h040, 4'h6, 4'hF, 1);            // R1 queue two-half memory read
    step(1, 0, 12'h040, 4'h6, 4'hF, 1);            // R3 retry while fetching
    step(1, 1, 12'h800, 4'h6, 4'h0, 0);            // R5 poll with FIFO busy
    finish_pending();                               // R3, R6 delivery
    step(1, 0, 12'h044, 4'h6, 4'hF, 0);            // R2 FIFO not empty
    idle(6);                                        // R2 no fetch must appear
    step(1, 0, 12'h100, 4'h6, 4'h3, 1);            // R1 low half only
    step(1, 0, 12'h104, 4'h6, 4'h3, 1);            // R4 other address
    step(1, 0, 12'h100, 4'h6, 4'h7, 1);            // R4 other enables
    step(1, 0, 12'h100, 4'hC, 4'h3, 1);            // R4 other command
    step(1, 1, 12'h100, 4'h6, 4'h3, 1);            // R10 other space, unmapped
    finish_pending();
    step(1, 0, 12'h0A0, 4'h6, 4'h8, 1);            // R6 single upper byte
    finish_pending();
    step(1, 0, 12'h0B0, 4'h6, 4'h0, 1);            // R6 no enables
    finish_pending();
    step(1, 1, 12'h010, 4'h6, 4'h1, 1);            // R7
    step(1, 1, 12'h010, 4'h6, 4'h7, 1);            // R7 upper single byte
    step(1, 1, 12'h010, 4'h6, 4'hC, 1);            // R8
    step(1, 1, 12'h010, 4'h6, 4'h0, 1);            // R8
    step(1, 1, 12'h020, 4'h6, 4'h3, 1);            // R9
    finish_pending();
    step(1, 1, 12'h81C, 4'h6, 4'hF, 1);            // R5 other offset reads 0
    step(1, 1, 12'h820, 4'h6, 4'hF, 1);            // R10
    step(1, 1, 12'h400, 4'h6, 4'hF, 1);            // R10
    for (int i = 0; i < 3000; i++) begin
      int ch;
      bit fe;
      ch = int'($urandom % 100);
      fe = ($urandom % 5) != 0;
      if (m_pend && ch < 45)
        step(1, m_reg, m_addr, m_cmd, m_be, fe);
      else if (ch < 55)
        step(0, 0, '0, '0, '0, fe);
      else if (ch < 62)
        step(1, 1, 12'h800 + 12'(4 * ($urandom % 8)), 4'h6, 4'(($urandom)), fe);
      else if (ch < 76)
        step(1, 1, (ch < 66) ? 12'h300 : 12'(4 * ($urandom % 64)), 4'h6, 4'($urandom), fe);
      else
        step(1, 0, 12'(4 * ($urandom % 16)), ($urandom % 2) ? 4'h6 : 4'hC, 4'($urandom), fe);
    end
    finish_pending();
    idle(2);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule